// File: doc/BRIEF.md
# Branch Trace Buffer with Repeat Folding

This block records changes in program flow as pairs of 32-bit addresses (where the branch came from, where it went). The CPU side presents one branch event per cycle with a hardware-loop flag and the current interrupt level. Software reaches the block through a 32-bit register port: a control register, a read-only occupancy count, and a data port that returns the newest entry first. Each entry takes two data-port reads. The first returns the destination. The second returns the source and removes the entry.

When the ring is full, the control register selects the outcome. The block either drops the oldest entry to make room, or it drops the event and raises a one-cycle overflow trap. Two optional folding modes absorb repeated branches without using a new slot. A match against the newest entry sets bit 0 of that entry's destination. A match against the entry before it sets bit 0 of that entry's source.

Each event is classified by a combinational decision with five outcomes: CAP_IDLE (no capture), CAP_PUSH (new entry), CAP_FOLD1 (fold into the newest entry), CAP_FOLD2 (fold into the second-newest entry) and CAP_TRAP (overflow trap). The drain sequencer is a two-state machine. In DRN_DEST the next data read returns a destination and moves to DRN_SRC. In DRN_SRC the next data read returns a source, pops the entry and moves back to DRN_DEST. A data read on an empty buffer leaves the state unchanged.

Top module: `brtrace_top`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0 and a data-port read returns 0.
- R2: The control register sits at byte offset 0x000 and keeps all 32 written bits. Its fields are bit 0 power, bit 1 enable, bit 2 overflow-trap mode, bit 3 fold-newest and bit 4 fold-second. Status sits at 0x004 and the data port at 0x100.
- R3: The error code is 0 for OK, 1 for a bad size and 2 for an unmapped offset. An access with `reg_size` other than 2 (32-bit) gets code 1, whatever its offset. A legal-size access to any other offset gets code 2. Writes to status or to the data port change nothing, and an access that fails has no side effect.
- R4: A status read returns the number of valid entries, capped at 16.
- R5: A data read on an empty buffer returns 0 and changes nothing. Otherwise data reads alternate: the newest entry's destination first, then its source, and the second read removes that entry.
- R6: An event is captured only when power and enable are both set. Events flagged as hardware loops are never captured, and nothing is captured at level 1 (the reset level).
- R7: While overflow-trap mode is set, events at levels 0 to 3 are not captured.
- R8: If the buffer is full and trap mode is set, a captured event is dropped and `ovf_exc` is high for exactly the one cycle after the event.
- R9: If the buffer is full and trap mode is clear, the oldest entry is discarded before folding is evaluated. A folded event therefore leaves 15 entries.
- R10: With fold-newest enabled and at least one entry present, an event whose addresses match the newest entry (ignoring bit 0) sets bit 0 of that entry's destination and adds no entry.
- R11: With fold-second enabled and at least two entries present, an event that matches the second-newest entry (ignoring bit 0) sets bit 0 of that entry's source and adds no entry. The fold-newest check takes priority.
- R12: Register responses appear in the cycle after the request. When an event and a data read arrive in the same cycle, the capture is applied first and the read sees its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | Branch event strobe |
| br_src | input | 32 | Branch source address |
| br_dst | input | 32 | Branch destination address |
| br_hwloop | input | 1 | Event comes from a hardware loop |
| br_level | input | 4 | Current interrupt level (1 = reset level, 0..3 = highest priorities) |
| reg_req | input | 1 | Register access request |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 9 | Byte offset of the access |
| reg_size | input | 2 | Access size code (2 = 32-bit) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read |
| reg_err | output | 2 | Response code, valid the cycle after a request |
| ovf_exc | output | 1 | One-cycle overflow trap pulse |

## Verification
The assertions assume that `reg_req` and `br_valid` are held low during reset, so that the first response after reset reflects only requests made after it. They also assume that every register input is driven to a known value whenever `reg_req` is high. The bench drives all inputs at the falling edge and forces the strobes low after every cycle. It builds events from a small address pool with random bit 0, so that both folding paths and full-buffer cases occur often. It keeps the size code mostly legal, so the buffer drains as well as fills.

// File: rtl/brtrace_pkg.sv
package brtrace_pkg;
    // register map (byte offsets)
    localparam logic [8:0] OFF_CTRL = 9'h000;
    localparam logic [8:0] OFF_STAT = 9'h004;
    localparam logic [8:0] OFF_DATA = 9'h100;
    localparam logic [1:0] SZ_WORD  = 2'd2;

    // control field positions
    localparam int unsigned CB_PWR   = 0;
    localparam int unsigned CB_EN    = 1;
    localparam int unsigned CB_OVX   = 2;
    localparam int unsigned CB_FOLD1 = 3;
    localparam int unsigned CB_FOLD2 = 4;

    // interrupt levels
    localparam logic [3:0] LVL_RESET = 4'd1;
    localparam logic [3:0] LVL_EXC   = 4'd3;

    localparam int unsigned STAT_CAP = 16;

    typedef enum logic [1:0] {
        RSP_OK       = 2'd0,
        RSP_SIZE     = 2'd1,
        RSP_UNMAPPED = 2'd2
    } rsp_t;

    typedef enum logic [2:0] {
        CAP_IDLE,
        CAP_PUSH,
        CAP_FOLD1,
        CAP_FOLD2,
        CAP_TRAP
    } cap_op_t;

    typedef enum logic {
        DRN_DEST,
        DRN_SRC
    } drn_state_t;
endpackage

// File: rtl/brtrace_capture.sv
module brtrace_capture
    import brtrace_pkg::*;
#(
    parameter int unsigned AW    = 32,
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
    input  logic          ev_valid,
    input  logic [AW-1:0] ev_src,
    input  logic [AW-1:0] ev_dst,
    input  logic          ev_hwloop,
    input  logic [3:0]    ev_level,
    input  logic [4:0]    ctrl_bits,
    input  logic [CW-1:0] count,
    input  logic [AW-1:0] last_src,
    input  logic [AW-1:0] last_dst,
    input  logic [AW-1:0] prev_src,
    input  logic [AW-1:0] prev_dst,
    output cap_op_t       op
);
    logic          allowed;
    logic          full;
    logic [CW-1:0] eff_cnt;
    logic          hit1;
    logic          hit2;

    always_comb begin
        allowed = ev_valid && ctrl_bits[CB_PWR] && ctrl_bits[CB_EN] && !ev_hwloop
                  && (ev_level != LVL_RESET)
                  && !((ev_level <= LVL_EXC) && ctrl_bits[CB_OVX]);
        full    = (count == CW'(DEPTH));
        // oldest slot is released before folding is considered
        eff_cnt = full ? CW'(DEPTH - 1) : count;
        hit1 = ctrl_bits[CB_FOLD1] && (eff_cnt >= CW'(1))
               && (ev_src[AW-1:1] == last_src[AW-1:1])
               && (ev_dst[AW-1:1] == last_dst[AW-1:1]);
        hit2 = ctrl_bits[CB_FOLD2] && (eff_cnt >= CW'(2))
               && (ev_src[AW-1:1] == prev_src[AW-1:1])
               && (ev_dst[AW-1:1] == prev_dst[AW-1:1]);
        op = CAP_IDLE;
        if (allowed) begin
            if (full && ctrl_bits[CB_OVX]) op = CAP_TRAP;
            else if (hit1)                 op = CAP_FOLD1;
            else if (hit2)                 op = CAP_FOLD2;
            else                           op = CAP_PUSH;
        end
    end
endmodule

// File: rtl/brtrace_store.sv
module brtrace_store
    import brtrace_pkg::*;
#(
    parameter int unsigned AW    = 32,
    parameter int unsigned DEPTH = 16,
    localparam int unsigned IW   = $clog2(DEPTH),
    localparam int unsigned CW   = IW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  cap_op_t       op,
    input  logic [AW-1:0] ev_src,
    input  logic [AW-1:0] ev_dst,
    input  logic          pop,
    output logic [CW-1:0] count,
    output logic [AW-1:0] last_src,
    output logic [AW-1:0] last_dst,
    output logic [AW-1:0] prev_src,
    output logic [AW-1:0] prev_dst,
    output logic [CW-1:0] count_post,
    output logic [AW-1:0] post_src,
    output logic [AW-1:0] post_dst
);
    logic [AW-1:0] mem_src [DEPTH];
    logic [AW-1:0] mem_dst [DEPTH];
    logic [IW-1:0] top_q;
    logic [IW-1:0] top_c;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_c;
    logic [IW-1:0] idx1;
    logic [IW-1:0] idx2;
    logic          full_q;

    assign idx1     = top_q - IW'(1);
    assign idx2     = top_q - IW'(2);
    assign full_q   = (cnt_q == CW'(DEPTH));
    assign count    = cnt_q;
    assign last_src = mem_src[idx1];
    assign last_dst = mem_dst[idx1];
    assign prev_src = mem_src[idx2];
    assign prev_dst = mem_dst[idx2];

    // view of the ring after this cycle's capture
    always_comb begin
        cnt_c    = cnt_q;
        top_c    = top_q;
        post_src = mem_src[idx1];
        post_dst = mem_dst[idx1];
        unique case (op)
            CAP_PUSH: begin
                top_c    = top_q + IW'(1);
                cnt_c    = full_q ? cnt_q : cnt_q + CW'(1);
                post_src = ev_src;
                post_dst = ev_dst;
            end
            CAP_FOLD1: begin
                if (full_q) cnt_c = CW'(DEPTH - 1);
                post_dst = mem_dst[idx1] | AW'(1);
            end
            CAP_FOLD2: begin
                if (full_q) cnt_c = CW'(DEPTH - 1);
            end
            default: ;
        endcase
    end
    assign count_post = cnt_c;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= '0;
            cnt_q <= '0;
        end else if (pop) begin
            top_q <= top_c - IW'(1);
            cnt_q <= cnt_c - CW'(1);
        end else begin
            top_q <= top_c;
            cnt_q <= cnt_c;
        end
    end

    always_ff @(posedge clk) begin
        case (op)
            CAP_PUSH: begin
                mem_src[top_q] <= ev_src;
                mem_dst[top_q] <= ev_dst;
            end
            CAP_FOLD1: mem_dst[idx1][0] <= 1'b1;
            CAP_FOLD2: mem_src[idx2][0] <= 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/brtrace_drain.sv
module brtrace_drain
    import brtrace_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_fire,
    input  logic [CW-1:0] count_post,
    input  logic [AW-1:0] post_src,
    input  logic [AW-1:0] post_dst,
    output logic          pop,
    output logic [AW-1:0] rd_value
);
    drn_state_t state_q;
    drn_state_t state_d;
    logic       live;

    assign live = rd_fire && (count_post != '0);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= DRN_DEST;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (live) begin
            unique case (state_q)
                DRN_DEST: state_d = DRN_SRC;
                DRN_SRC:  state_d = DRN_DEST;
            endcase
        end
    end

    // outputs
    always_comb begin
        pop      = 1'b0;
        rd_value = '0;
        if (live) begin
            unique case (state_q)
                DRN_DEST: rd_value = post_dst;
                DRN_SRC: begin
                    rd_value = post_src;
                    pop      = 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/brtrace_top.sv
module brtrace_top
    import brtrace_pkg::*;
#(
    parameter int unsigned AW         = 32,
    parameter int unsigned DEPTH_LOG2 = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          br_valid,
    input  logic [AW-1:0] br_src,
    input  logic [AW-1:0] br_dst,
    input  logic          br_hwloop,
    input  logic [3:0]    br_level,
    input  logic          reg_req,
    input  logic          reg_wr,
    input  logic [8:0]    reg_addr,
    input  logic [1:0]    reg_size,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic [1:0]    reg_err,
    output logic          ovf_exc
);
    localparam int unsigned DEPTH = 1 << DEPTH_LOG2;
    localparam int unsigned CW    = DEPTH_LOG2 + 1;

    logic [31:0]   ctrl_q;
    cap_op_t       op;
    logic [CW-1:0] count;
    logic [CW-1:0] count_post;
    logic [AW-1:0] last_src, last_dst, prev_src, prev_dst;
    logic [AW-1:0] post_src, post_dst;
    logic          pop;
    logic [AW-1:0] rd_value;

    logic size_ok, hit_ctrl, hit_stat, hit_data, data_rd;
    rsp_t        rsp_d;
    logic [31:0] rdata_d;
    logic [31:0] stat_val;

    assign size_ok  = (reg_size == SZ_WORD);
    assign hit_ctrl = (reg_addr == OFF_CTRL);
    assign hit_stat = (reg_addr == OFF_STAT);
    assign hit_data = (reg_addr == OFF_DATA);
    assign data_rd  = reg_req && !reg_wr && size_ok && hit_data;
    assign stat_val = (32'(count_post) > 32'(STAT_CAP)) ? 32'(STAT_CAP) : 32'(count_post);

    brtrace_capture #(.AW(AW), .DEPTH(DEPTH)) u_capture (
        .ev_valid  (br_valid),
        .ev_src    (br_src),
        .ev_dst    (br_dst),
        .ev_hwloop (br_hwloop),
        .ev_level  (br_level),
        .ctrl_bits (ctrl_q[4:0]),
        .count     (count),
        .last_src  (last_src),
        .last_dst  (last_dst),
        .prev_src  (prev_src),
        .prev_dst  (prev_dst),
        .op        (op)
    );

    brtrace_store #(.AW(AW), .DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .op         (op),
        .ev_src     (br_src),
        .ev_dst     (br_dst),
        .pop        (pop),
        .count      (count),
        .last_src   (last_src),
        .last_dst   (last_dst),
        .prev_src   (prev_src),
        .prev_dst   (prev_dst),
        .count_post (count_post),
        .post_src   (post_src),
        .post_dst   (post_dst)
    );

    brtrace_drain #(.AW(AW), .CW(CW)) u_drain (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_fire    (data_rd),
        .count_post (count_post),
        .post_src   (post_src),
        .post_dst   (post_dst),
        .pop        (pop),
        .rd_value   (rd_value)
    );

    // response decode: size error outranks unmapped offset
    always_comb begin
        rsp_d   = RSP_OK;
        rdata_d = '0;
        if (reg_req) begin
            if (!size_ok)                              rsp_d = RSP_SIZE;
            else if (!(hit_ctrl || hit_stat || hit_data)) rsp_d = RSP_UNMAPPED;
            else if (!reg_wr) begin
                if (hit_ctrl)      rdata_d = ctrl_q;
                else if (hit_stat) rdata_d = stat_val;
                else               rdata_d = 32'(rd_value);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            reg_rdata <= '0;
            reg_err   <= RSP_OK;
            ovf_exc   <= 1'b0;
        end else begin
            if (reg_req && reg_wr && size_ok && hit_ctrl) ctrl_q <= reg_wdata;
            reg_rdata <= rdata_d;
            reg_err   <= rsp_d;
            ovf_exc   <= (op == CAP_TRAP);
        end
    end
endmodule

// File: rtl/brtrace_chk.sv
module brtrace_chk
    import brtrace_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        br_valid,
    input logic        br_hwloop,
    input logic [3:0]  br_level,
    input logic        reg_req,
    input logic        reg_wr,
    input logic [8:0]  reg_addr,
    input logic [1:0]  reg_size,
    input logic [31:0] reg_rdata,
    input logic [1:0]  reg_err,
    input logic        ovf_exc,
    input logic [31:0] ctrl_q
);
    assert_size_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_req && (reg_size != SZ_WORD)) |-> (reg_err == RSP_SIZE));

    assert_unmapped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_req && (reg_size == SZ_WORD) && (reg_addr != OFF_CTRL)
              && (reg_addr != OFF_STAT) && (reg_addr != OFF_DATA))
        |-> (reg_err == RSP_UNMAPPED));

    assert_ctrl_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!(reg_req && reg_wr && (reg_size == SZ_WORD) && (reg_addr == OFF_CTRL)))
        |-> $stable(ctrl_q));

    assert_ctrl_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_req && !reg_wr && (reg_size == SZ_WORD) && (reg_addr == OFF_CTRL))
        |-> (reg_rdata == $past(ctrl_q)));

    assert_stat_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_req && !reg_wr && (reg_size == SZ_WORD) && (reg_addr == OFF_STAT))
        |-> (reg_rdata <= 32'(STAT_CAP)));

    assert_trap_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_exc |-> $past(br_valid && !br_hwloop && ctrl_q[CB_PWR]
                          && ctrl_q[CB_EN] && ctrl_q[CB_OVX]));

    assert_trap_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_exc |-> $past(br_level > LVL_EXC));
endmodule

bind brtrace_top brtrace_chk u_chk (.*);

// File: tb/sim_brtrace_top.sv
module sim_brtrace_top;
    import brtrace_pkg::*;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        br_valid = 1'b0, br_hwloop = 1'b0;
    logic [31:0] br_src = '0, br_dst = '0;
    logic [3:0]  br_level = '0;
    logic        reg_req = 1'b0, reg_wr = 1'b0;
    logic [8:0]  reg_addr = '0;
    logic [1:0]  reg_size = 2'd2;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  reg_err;
    logic        ovf_exc;

    always #2 clk = ~clk;   // 250 MHz

    brtrace_top u0 (.*);

    int n_run = 0, n_fail = 0;
    logic [31:0] q_src [DEPTH];
    logic [31:0] q_dst [DEPTH];
    int          qlen = 0;
    bit          mid = 0;
    logic [31:0] m_ctrl = '0;
    logic [31:0] last_rd = '0;

    // returns 1 when the event must raise the overflow trap
    function automatic bit m_capture(bit v, logic [31:0] s, logic [31:0] d, bit hw, logic [3:0] lvl);
        if (!v || !m_ctrl[0] || !m_ctrl[1] || hw || lvl == 4'd1 || (lvl <= 4'd3 && m_ctrl[2])) return 0;
        if (qlen == DEPTH) begin
            if (m_ctrl[2]) return 1;
            for (int i = 0; i < DEPTH - 1; i++) begin
                q_src[i] = q_src[i+1];
                q_dst[i] = q_dst[i+1];
            end
            qlen--;
        end
        if (m_ctrl[3] && qlen >= 1 && q_src[qlen-1][31:1] == s[31:1] && q_dst[qlen-1][31:1] == d[31:1]) begin
            q_dst[qlen-1][0] = 1'b1;
            return 0;
        end
        if (m_ctrl[4] && qlen >= 2 && q_src[qlen-2][31:1] == s[31:1] && q_dst[qlen-2][31:1] == d[31:1]) begin
            q_src[qlen-2][0] = 1'b1;
            return 0;
        end
        q_src[qlen] = s;
        q_dst[qlen] = d;
        qlen++;
        return 0;
    endfunction

    function automatic void m_access(bit wr, logic [8:0] a, logic [1:0] sz, logic [31:0] wd,
                                     output logic [1:0] e, output logic [31:0] r);
        e = 2'd0;
        r = '0;
        if (sz != 2'd2) begin e = 2'd1; return; end
        if (a == 9'h000) begin
            if (wr) m_ctrl = wd; else r = m_ctrl;
        end else if (a == 9'h004) begin
            if (!wr) r = (qlen > 16) ? 32'd16 : 32'(qlen);
        end else if (a == 9'h100) begin
            if (!wr && qlen != 0) begin
                if (!mid) begin r = q_dst[qlen-1]; mid = 1; end
                else begin r = q_src[qlen-1]; qlen--; mid = 0; end
            end
        end else e = 2'd2;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(bit v, logic [31:0] s, logic [31:0] d, bit hw, logic [3:0] lvl,
                       bit rq, bit wr, logic [8:0] a, logic [1:0] sz, logic [31:0] wd, string tag);
        bit trap;
        logic [1:0]  e;
        logic [31:0] r;
        @(negedge clk);
        br_valid = v; br_src = s; br_dst = d; br_hwloop = hw; br_level = lvl;
        reg_req = rq; reg_wr = wr; reg_addr = a; reg_size = sz; reg_wdata = wd;
        trap = m_capture(v, s, d, hw, lvl);
        e = 2'd0; r = '0;
        if (rq) m_access(wr, a, sz, wd, e, r);
        @(posedge clk);
        #1;
        if (v) chk({tag, " R8 trap"}, 32'(ovf_exc), 32'(trap));
        if (rq) chk({tag, " R3 err"}, 32'(reg_err), 32'(e));
        if (rq && !wr) begin
            chk({tag, " data"}, reg_rdata, r);
            last_rd = reg_rdata;
        end
        br_valid = 1'b0; br_hwloop = 1'b0; reg_req = 1'b0;
    endtask

    task automatic ev(logic [31:0] s, logic [31:0] d, logic [3:0] lvl);
        cyc(1, s, d, 0, lvl, 0, 0, 9'h0, 2'd2, '0, "event");
    endtask
    task automatic wrr(logic [8:0] a, logic [31:0] wd);
        cyc(0, '0, '0, 0, 4'd0, 1, 1, a, 2'd2, wd, "write");
    endtask
    task automatic rdk(logic [8:0] a, logic [31:0] exp, string tag);
        cyc(0, '0, '0, 0, 4'd0, 1, 0, a, 2'd2, '0, tag);
        chk(tag, last_rd, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd7319));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rdk(9'h000, 32'h0, "R1 ctrl");
        rdk(9'h004, 32'h0, "R1 stat");
        rdk(9'h100, 32'h0, "R1 data");

        // R2 control read-back
        wrr(9'h000, 32'hABCD_0003);
        rdk(9'h000, 32'hABCD_0003, "R2 ctrl");

        // R6 gating
        cyc(1, 32'h100, 32'h200, 1, 4'd5, 0, 0, 9'h0, 2'd2, '0, "R6 hwloop");
        ev(32'h100, 32'h200, 4'd1);
        rdk(9'h004, 32'h0, "R6 hwloop/reset level");
        wrr(9'h000, 32'h1);
        ev(32'h100, 32'h200, 4'd5);
        rdk(9'h004, 32'h0, "R6 enable off");
        wrr(9'h000, 32'h2);
        ev(32'h100, 32'h200, 4'd5);
        rdk(9'h004, 32'h0, "R6 power off");

        // R4 / R5 basic drain
        wrr(9'h000, 32'h3);
        ev(32'h100, 32'h200, 4'd5);
        rdk(9'h004, 32'd1, "R4 count");
        rdk(9'h100, 32'h200, "R5 dst first");
        rdk(9'h100, 32'h100, "R5 src second");
        rdk(9'h004, 32'd0, "R5 entry removed");

        // R10 fold newest
        wrr(9'h000, 32'h0B);
        ev(32'h100, 32'h200, 4'd5);
        ev(32'h100, 32'h200, 4'd5);
        ev(32'h101, 32'h200, 4'd5);
        rdk(9'h004, 32'd1, "R10 no new entry");
        rdk(9'h100, 32'h201, "R10 dst bit0");
        rdk(9'h100, 32'h100, "R10 src");

        // R11 fold second-newest
        wrr(9'h000, 32'h13);
        ev(32'h100, 32'h200, 4'd5);
        ev(32'h300, 32'h400, 4'd5);
        ev(32'h100, 32'h200, 4'd5);
        rdk(9'h004, 32'd2, "R11 no new entry");
        rdk(9'h100, 32'h400, "R11 newest dst");
        rdk(9'h100, 32'h300, "R11 newest src");
        rdk(9'h100, 32'h200, "R11 older dst");
        rdk(9'h100, 32'h101, "R11 src bit0");

        // R11 priority of fold-newest
        wrr(9'h000, 32'h1B);
        ev(32'h100, 32'h200, 4'd5);
        ev(32'h300, 32'h400, 4'd5);
        ev(32'h300, 32'h400, 4'd5);
        rdk(9'h004, 32'd2, "R11 prio count");
        rdk(9'h100, 32'h401, "R11 prio newest dst");
        rdk(9'h100, 32'h300, "R11 prio newest src");
        rdk(9'h100, 32'h200, "R11 prio older dst");
        rdk(9'h100, 32'h100, "R11 prio older src");

        // R12 capture before same-cycle read
        cyc(1, 32'h100, 32'h200, 0, 4'd5, 1, 0, 9'h100, 2'd2, '0, "R12 same cycle");
        chk("R12 read sees capture", last_rd, 32'h200);
        rdk(9'h100, 32'h100, "R12 src");
        rdk(9'h004, 32'd0, "R12 empty");

        // R9 overwrite oldest
        wrr(9'h000, 32'h3);
        for (int i = 0; i <= 16; i++) ev(32'h1000 + 32'(i*8), 32'h2000 + 32'(i*8), 4'd6);
        rdk(9'h004, 32'd16, "R9 full");
        for (int i = 16; i >= 1; i--) begin
            rdk(9'h100, 32'h2000 + 32'(i*8), "R9 drain dst");
            rdk(9'h100, 32'h1000 + 32'(i*8), "R9 drain src");
        end
        rdk(9'h004, 32'd0, "R9 oldest gone");

        // R9 discard happens before folding
        wrr(9'h000, 32'h0B);
        for (int i = 0; i < 16; i++) ev(32'h1000 + 32'(i*8), 32'h2000 + 32'(i*8), 4'd6);
        ev(32'h1000 + 32'(15*8), 32'h2000 + 32'(15*8), 4'd6);
        rdk(9'h004, 32'd15, "R9 fold on full");
        rdk(9'h100, 32'h2000 + 32'(15*8) + 32'h1, "R9 folded dst");
        rdk(9'h100, 32'h1000 + 32'(15*8), "R9 folded src");

        // R8 trap on full
        wrr(9'h000, 32'h7);
        ev(32'h5000, 32'h6000, 4'd6);
        ev(32'h5008, 32'h6008, 4'd6);
        rdk(9'h004, 32'd16, "R8 full");
        ev(32'h7000, 32'h7100, 4'd6);
        chk("R8 pulse", 32'(ovf_exc), 32'd1);
        cyc(0, '0, '0, 0, 4'd0, 0, 0, 9'h0, 2'd2, '0, "idle");
        chk("R8 one cycle", 32'(ovf_exc), 32'd0);
        rdk(9'h004, 32'd16, "R8 dropped");
        rdk(9'h100, 32'h6008, "R8 newest kept");

        // R7 high-priority levels blocked
        rdk(9'h100, 32'h5008, "R7 pop");
        ev(32'h7000, 32'h7100, 4'd2);
        ev(32'h7000, 32'h7100, 4'd3);
        rdk(9'h004, 32'd15, "R7 blocked");
        ev(32'h7000, 32'h7100, 4'd4);
        rdk(9'h004, 32'd16, "R7 level above");

        // R3 error codes and ignored writes
        cyc(0, '0, '0, 0, 4'd0, 1, 0, 9'h100, 2'd0, '0, "R3 size");
        chk("R3 size code", 32'(reg_err), 32'd1);
        cyc(0, '0, '0, 0, 4'd0, 1, 0, 9'h008, 2'd1, '0, "R3 prio");
        chk("R3 size over unmapped", 32'(reg_err), 32'd1);
        cyc(0, '0, '0, 0, 4'd0, 1, 0, 9'h008, 2'd2, '0, "R3 unmapped");
        chk("R3 unmapped code", 32'(reg_err), 32'd2);
        wrr(9'h004, 32'h0);
        wrr(9'h100, 32'h0);
        cyc(0, '0, '0, 0, 4'd0, 1, 1, 9'h000, 2'd1, 32'h0, "R3 bad write");
        rdk(9'h004, 32'd16, "R3 status write ignored");
        rdk(9'h000, 32'h7, "R3 ctrl unchanged");

        // constrained random
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] s, d, wd;
            logic [8:0]  a;
            logic [1:0]  sz;
            bit v, hw, rq, wr;
            s  = (32'h100 << ($urandom % 3)) | 32'($urandom % 2);
            d  = (32'h4000 << ($urandom % 3)) | 32'($urandom % 2);
            v  = ($urandom % 3) != 0;
            hw = ($urandom % 8) == 0;
            rq = ($urandom % 2) == 0;
            wr = ($urandom % 8) == 0;
            case ($urandom % 6)
                0: a = 9'h000;
                1: a = 9'h004;
                5: a = 9'h008;
                default: a = 9'h100;
            endcase
            sz = (($urandom % 10) == 0) ? 2'($urandom % 4) : 2'd2;
            wd = (($urandom % 4) != 0) ? ($urandom | 32'h3) : $urandom;
            cyc(v, s, d, hw, 4'($urandom % 16), rq, wr, a, sz, wd, "random R5");
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule